// File: doc/BRIEF.md
# Two-Input Slave Serial Audio Receiver

This block takes stereo serial audio from one of two external transmitters. On each input the external device is the master: it drives the bit clock and the word select, and the block never generates either one. The block samples the three lines of every input on its own system clock. A select bit picks which input feeds the deserializer. A 3-bit format code chooses the framing. The choices are standard I2S framing (MSB first, one bit after the word-select change) or right-justified framing, in which the last 16, 18 or 20 bits before a word-select change make up the sample.

The block holds the left word and the right word of each word-select period. When the period ends it checks how many bit-clock rising edges the period had. If the count is inside the legal range, both channels come out together as 24-bit words, sign-extended from the sample width, and each channel has its own one-clock strobe. If the count is outside the range, the block discards the pair and pulses an error flag. After reset, and after any change of the input select or the format code, the block drops the first partial frame so that it never presents a mixed sample.

Top module: `i2s_slave_rx`

## Requirements
- R1: `src_sel` = 0 takes input lane 0 and `src_sel` = 1 takes input lane 1 (bit index in the `*_in` vectors). Activity on the unselected lane has no effect on the outputs.
- R2: With `fmt_code` = 3'b100 (I2S), word select low marks the left channel. The sample MSB is the bit taken at the second bit-clock rising edge after a word-select change. The first 24 bits form the output MSB-aligned, a word shorter than 24 bits has zeros in the missing LSBs, and bits past the 24th are ignored.
- R3: With `fmt_code` = 3'b001, each channel word is the last 16 bits received before the word select changes, sign-extended from bit 15 to 24 bits.
- R4: With `fmt_code` = 3'b010, each channel word is the last 18 bits before the word-select change, sign-extended from bit 17.
- R5: With `fmt_code` = 3'b011, each channel word is the last 20 bits before the word-select change, sign-extended from bit 19.
- R6: A frame is one word-select period: a left word followed by a right word. After the right word completes, `left_valid` and `right_valid` pulse together for one clock. `left_data` and `right_data` then hold until the next accepted frame.
- R7: A frame with 16 to 256 bit-clock rising edges (inclusive) is accepted. A frame with fewer or more edges gives a one-clock `frame_err` pulse, no strobes, and no change to the data outputs.
- R8: Reset clears both data outputs, both strobes and `frame_err`. The first frame seen after reset, and after any change of `src_sel` or `fmt_code`, produces no output and no error.
- R9: Format codes 3'b000, 3'b101, 3'b110 and 3'b111 behave exactly like 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | SEL_W (1) | Input lane select |
| fmt_code | input | 3 | Framing format code |
| bck_in | input | N_SRC (2) | Bit clock of each lane |
| ws_in | input | N_SRC (2) | Word select of each lane |
| sd_in | input | N_SRC (2) | Serial data of each lane |
| left_data | output | OUT_W (24) | Left sample, sign-extended |
| left_valid | output | 1 | One-clock strobe for a new left sample |
| right_data | output | OUT_W (24) | Right sample, sign-extended |
| right_valid | output | 1 | One-clock strobe for a new right sample |
| frame_err | output | 1 | One-clock pulse for a frame with an illegal bit count |

## Verification
A wrong word boundary or a lost one-bit I2S delay shows up in the very next accepted frame. The word comes out shifted by one position, which is easy to see against the MSB-first reference values, and in the right-justified modes the sign extension comes from the wrong bit. A miscounted frame length appears at the end of the frame it belongs to, as a missing error pulse or as a strobe where the error should be. The check at 12, 16, 256 and 258 edges catches an off-by-one error in either limit. If the restart logic fails to re-arm after a change of select or format, a strobe appears during the warm-up frame. If it never re-arms, the expected pairs are missing when the run ends.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

   typedef enum logic [1:0] {
      FR_I2S  = 2'd0,
      FR_RJ16 = 2'd1,
      FR_RJ18 = 2'd2,
      FR_RJ20 = 2'd3
   } frame_kind_e;

   localparam int RJ_VARIANTS = 3;

   // Right-justified sample width of variant g (g = 0..2)
   function automatic int rj_width(input int g);
      return 16 + 2 * g;
   endfunction

   // Code decode: reserved and test codes fall back to I2S framing
   function automatic frame_kind_e decode_fmt(input logic [2:0] code);
      case (code)
         3'b001:  return FR_RJ16;
         3'b010:  return FR_RJ18;
         3'b011:  return FR_RJ20;
         default: return FR_I2S;
      endcase
   endfunction

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
   import i2s_rx_pkg::*;
#(
   parameter int OUT_W  = 24,
   parameter int RJ_MAX = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             bit_rise,
   input  logic             ws_bit,
   input  logic             sd_bit,
   input  frame_kind_e      kind,
   output logic             bit_stb,
   output logic             word_done,
   output logic             word_chan,
   output logic [OUT_W-1:0] word_data
);
   localparam int K_W   = $clog2(OUT_W + 1);
   localparam int IDX_W = $clog2(OUT_W);

   logic [RJ_MAX-1:0] sh;
   logic [OUT_W-1:0]  acc;
   logic [K_W-1:0]    k;
   logic [1:0]        prime;
   logic              ws_e1;
   logic              wsd_last;
   logic              wsd_now;
   logic              boundary;
   logic [IDX_W-1:0]  acc_idx;
   logic [OUT_W-1:0]  rj_word [RJ_VARIANTS];
   logic [OUT_W-1:0]  rj_sel;

   // One candidate word per right-justified width
   for (genvar g = 0; g < RJ_VARIANTS; g++) begin : g_rj
      localparam int N = rj_width(g);
      assign rj_word[g] = {{(OUT_W - N){sh[N-1]}}, sh[N-1:0]};
   end

   always_comb begin
      case (kind)
         FR_RJ16: rj_sel = rj_word[0];
         FR_RJ18: rj_sel = rj_word[1];
         FR_RJ20: rj_sel = rj_word[2];
         default: rj_sel = '0;
      endcase
   end

   // I2S sees the word select one bit late; right-justified sees it at once
   assign wsd_now  = (kind == FR_I2S) ? ws_e1 : ws_bit;
   assign boundary = (prime == 2'd2) && (wsd_now != wsd_last);
   assign acc_idx  = IDX_W'(OUT_W - 1 - int'(k));

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         sh        <= '0;
         acc       <= '0;
         k         <= '0;
         prime     <= '0;
         ws_e1     <= 1'b0;
         wsd_last  <= 1'b0;
         bit_stb   <= 1'b0;
         word_done <= 1'b0;
         word_chan <= 1'b0;
         word_data <= '0;
      end else begin
         bit_stb   <= bit_rise;
         word_done <= 1'b0;
         if (bit_rise) begin
            ws_e1    <= ws_bit;
            wsd_last <= wsd_now;
            sh       <= {sh[RJ_MAX-2:0], sd_bit};
            if (prime != 2'd2) prime <= prime + 2'd1;
            if (boundary) begin
               word_done <= 1'b1;
               word_chan <= wsd_last;
               word_data <= (kind == FR_I2S) ? acc : rj_sel;
               acc       <= {sd_bit, {(OUT_W-1){1'b0}}};
               k         <= K_W'(1);
            end else if (k < K_W'(OUT_W)) begin
               acc[acc_idx] <= sd_bit;
               k            <= k + K_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/i2s_rx_frame.sv
module i2s_rx_frame #(
   parameter int OUT_W   = 24,
   parameter int MIN_BCK = 16,
   parameter int MAX_BCK = 256
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             bit_stb,
   input  logic             word_done,
   input  logic             word_chan,
   input  logic [OUT_W-1:0] word_data,
   output logic [OUT_W-1:0] left_data,
   output logic [OUT_W-1:0] right_data,
   output logic             left_valid,
   output logic             right_valid,
   output logic             frame_err
);
   localparam int CNT_W = $clog2(MAX_BCK + 2);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BCK + 1);
   localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(MIN_BCK);
   localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(MAX_BCK);

   logic [CNT_W-1:0] cnt;
   logic [OUT_W-1:0] left_hold;
   logic             armed;
   logic             left_seen;
   logic             frame_end;
   logic             len_ok;

   assign frame_end = bit_stb && word_done && word_chan;
   assign len_ok    = (cnt >= CNT_LO) && (cnt <= CNT_HI);

   always_ff @(posedge clk) begin
      if (rst) begin
         left_data  <= '0;
         right_data <= '0;
      end else if (frame_end && armed && left_seen && len_ok) begin
         left_data  <= left_hold;
         right_data <= word_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt         <= '0;
         left_hold   <= '0;
         armed       <= 1'b0;
         left_seen   <= 1'b0;
         left_valid  <= 1'b0;
         right_valid <= 1'b0;
         frame_err   <= 1'b0;
      end else begin
         left_valid  <= 1'b0;
         right_valid <= 1'b0;
         frame_err   <= 1'b0;
         if (frame_end) begin
            cnt       <= CNT_W'(1);
            armed     <= 1'b1;
            left_seen <= 1'b0;
            if (armed && left_seen) begin
               left_valid  <= len_ok;
               right_valid <= len_ok;
               frame_err   <= !len_ok;
            end
         end else if (bit_stb) begin
            if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
            if (word_done && armed) begin
               left_hold <= word_data;
               left_seen <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx
   import i2s_rx_pkg::*;
#(
   parameter int N_SRC    = 2,
   parameter int SEL_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   parameter int OUT_W    = 24,
   parameter int RJ_MAX   = 20,
   parameter int MIN_BCK  = 16,
   parameter int MAX_BCK  = 256,
   parameter int SYNC_LEN = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] src_sel,
   input  logic [2:0]       fmt_code,
   input  logic [N_SRC-1:0] bck_in,
   input  logic [N_SRC-1:0] ws_in,
   input  logic [N_SRC-1:0] sd_in,
   output logic [OUT_W-1:0] left_data,
   output logic             left_valid,
   output logic [OUT_W-1:0] right_data,
   output logic             right_valid,
   output logic             frame_err
);
   // Elaboration-time parameter checks
   if (OUT_W < RJ_MAX)      begin : g_chk_out  $error("OUT_W must cover RJ_MAX"); end
   if (RJ_MAX < 20)         begin : g_chk_rj   $error("RJ_MAX must be at least 20"); end
   if (MIN_BCK < 4)         begin : g_chk_min  $error("MIN_BCK too small"); end
   if (MAX_BCK <= MIN_BCK)  begin : g_chk_max  $error("MAX_BCK must exceed MIN_BCK"); end
   if (SYNC_LEN < 2)        begin : g_chk_sync $error("SYNC_LEN must be at least 2"); end
   if (N_SRC < 1)           begin : g_chk_src  $error("N_SRC must be positive"); end

   localparam int CFG_W = SEL_W + 3;

   logic [2:0]       lane_s [N_SRC];
   logic [2:0]       pick;
   logic             bck_prev;
   logic             bit_rise;
   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;
   logic             restart;
   frame_kind_e      kind;
   logic             bit_stb;
   logic             word_done;
   logic             word_chan;
   logic [OUT_W-1:0] word_data;

   for (genvar g = 0; g < N_SRC; g++) begin : g_lane
      i2s_rx_sync #(.STAGES(SYNC_LEN), .W(3)) u_sync (
         .clk (clk),
         .rst (rst),
         .d   ({bck_in[g], ws_in[g], sd_in[g]}),
         .q   (lane_s[g])
      );
   end

   always_comb begin
      pick = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (int'(src_sel) == i) pick = lane_s[i];
      end
   end

   assign cfg_now  = {src_sel, fmt_code};
   assign restart  = (cfg_now != cfg_q);
   assign bit_rise = pick[2] && !bck_prev;
   assign kind     = decode_fmt(fmt_code);

   always_ff @(posedge clk) begin
      if (rst) begin
         bck_prev <= 1'b0;
         cfg_q    <= {{SEL_W{1'b0}}, 3'b100};
      end else begin
         bck_prev <= pick[2];
         cfg_q    <= cfg_now;
      end
   end

   i2s_rx_deser #(.OUT_W(OUT_W), .RJ_MAX(RJ_MAX)) u_deser (
      .clk       (clk),
      .rst       (rst),
      .restart   (restart),
      .bit_rise  (bit_rise),
      .ws_bit    (pick[1]),
      .sd_bit    (pick[0]),
      .kind      (kind),
      .bit_stb   (bit_stb),
      .word_done (word_done),
      .word_chan (word_chan),
      .word_data (word_data)
   );

   i2s_rx_frame #(.OUT_W(OUT_W), .MIN_BCK(MIN_BCK), .MAX_BCK(MAX_BCK)) u_frame (
      .clk         (clk),
      .rst         (rst),
      .restart     (restart),
      .bit_stb     (bit_stb),
      .word_done   (word_done),
      .word_chan   (word_chan),
      .word_data   (word_data),
      .left_data   (left_data),
      .right_data  (right_data),
      .left_valid  (left_valid),
      .right_valid (right_valid),
      .frame_err   (frame_err)
   );
endmodule

// File: rtl/i2s_slave_rx_chk.sv
module i2s_slave_rx_chk #(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst,
   input logic [2:0]       fmt_code,
   input logic [OUT_W-1:0] left_data,
   input logic             left_valid,
   input logic [OUT_W-1:0] right_data,
   input logic             right_valid,
   input logic             frame_err
);
   p_pair_r6: assert property (@(posedge clk) disable iff (rst)
      left_valid == right_valid);

   p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      left_valid |=> !left_valid);

   p_err_novalid_r7: assert property (@(posedge clk) disable iff (rst)
      frame_err |-> (!left_valid && !right_valid));

   p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
      frame_err |=> ($stable(left_data) && $stable(right_data)));

   p_sext16_r3: assert property (@(posedge clk) disable iff (rst)
      (left_valid && fmt_code == 3'b001 && $past(fmt_code) == 3'b001 &&
       $past(fmt_code, 2) == 3'b001)
      |-> (((left_data[OUT_W-1:15] == '0) || (left_data[OUT_W-1:15] == '1)) &&
           ((right_data[OUT_W-1:15] == '0) || (right_data[OUT_W-1:15] == '1))));

   p_sext20_r5: assert property (@(posedge clk) disable iff (rst)
      (left_valid && fmt_code == 3'b011 && $past(fmt_code) == 3'b011 &&
       $past(fmt_code, 2) == 3'b011)
      |-> (((left_data[OUT_W-1:19] == '0) || (left_data[OUT_W-1:19] == '1)) &&
           ((right_data[OUT_W-1:19] == '0) || (right_data[OUT_W-1:19] == '1))));
endmodule

bind i2s_slave_rx i2s_slave_rx_chk #(.OUT_W(OUT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .fmt_code    (fmt_code),
   .left_data   (left_data),
   .left_valid  (left_valid),
   .right_data  (right_data),
   .right_valid (right_valid),
   .frame_err   (frame_err)
);

// File: tb/test_i2s_slave_rx.sv
module test_i2s_slave_rx;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BCK   = 2;

   typedef struct packed {
      logic        err;
      logic [23:0] l;
      logic [23:0] r;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [0:0]  src_sel = 1'b0;
   logic [2:0]  fmt_code = 3'b100;
   logic [1:0]  bck_in = 2'b00;
   logic [1:0]  ws_in = 2'b00;
   logic [1:0]  sd_in = 2'b00;
   logic [23:0] left_data, right_data;
   logic        left_valid, right_valid, frame_err;

   int   checks = 0;
   int   errors = 0;
   exp_t exp_q[$];
   string tag_q[$];
   int   cur_src = 0;
   int   cur_n = 0;
   logic pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2s_slave_rx i_i2s_slave_rx (
      .clk (clk), .rst (rst), .src_sel (src_sel), .fmt_code (fmt_code),
      .bck_in (bck_in), .ws_in (ws_in), .sd_in (sd_in),
      .left_data (left_data), .left_valid (left_valid),
      .right_data (right_data), .right_valid (right_valid),
      .frame_err (frame_err)
   );

   function automatic logic [23:0] sx(input logic [23:0] v, input int n);
      logic signed [23:0] t;
      t = v << (24 - n);
      return 24'(t >>> (24 - n));
   endfunction

   task automatic slot(input logic w, input logic d);
      @(negedge clk);
      bck_in = 2'b00;
      ws_in  = {w, w};
      sd_in  = (cur_src == 1) ? {d, ~d} : {~d, d};
      repeat (HALF_BCK - 1) @(negedge clk);
      @(negedge clk);
      bck_in = 2'b11;
      repeat (HALF_BCK - 1) @(negedge clk);
   endtask

   task automatic set_cfg(input int src, input logic [2:0] code, input int n);
      @(negedge clk);
      src_sel  = 1'(src);
      fmt_code = code;
      cur_src  = src;
      cur_n    = n;
   endtask

   // nb bit slots per channel; cur_n = 0 means I2S framing
   task automatic send_frame(input int nb, input logic [23:0] l, input logic [23:0] r,
                             input bit expect_it, input bit is_err, input string tag);
      exp_t e;
      if (expect_it) begin
         e.err = is_err;
         if (cur_n == 0) begin
            e.l = (nb >= 24) ? l : (l & (24'hFFFFFF << (24 - nb)));
            e.r = (nb >= 24) ? r : (r & (24'hFFFFFF << (24 - nb)));
         end else begin
            e.l = sx(l, cur_n);
            e.r = sx(r, cur_n);
         end
         if (is_err) begin e.l = '0; e.r = '0; end
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
      for (int ch = 0; ch < 2; ch++) begin
         logic [23:0] v;
         v = (ch == 1) ? r : l;
         for (int j = 0; j < nb; j++) begin
            logic ideal;
            if (cur_n == 0)
               ideal = (j < 24) ? v[23 - j] : 1'b1;
            else
               ideal = (j >= nb - cur_n) ? v[cur_n - 1 - (j - (nb - cur_n))] : 1'b1;
            if (cur_n == 0) begin
               slot(1'(ch), pend);
               pend = ideal;
            end else begin
               slot(1'(ch), ideal);
            end
         end
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (!rst && (left_valid || right_valid || frame_err)) begin
         checks++;
         if (left_valid != right_valid) begin
            errors++;
            $display("FAIL R6 strobe pairing actual %b/%b expected equal", left_valid, right_valid);
         end
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected output actual valid=%b err=%b expected none",
                     left_valid, frame_err);
         end else begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e.err) begin
               if (!frame_err || left_valid) begin
                  errors++;
                  $display("FAIL %s actual err=%b valid=%b expected err=1 valid=0",
                           t, frame_err, left_valid);
               end
            end else if (frame_err || left_data != e.l || right_data != e.r) begin
               errors++;
               $display("FAIL %s actual err=%b L=%h R=%h expected err=0 L=%h R=%h",
                        t, frame_err, left_data, right_data, e.l, e.r);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (left_data != 0 || right_data != 0 || left_valid || right_valid || frame_err) begin
         errors++;
         $display("FAIL R8 reset state actual L=%h R=%h v=%b%b e=%b expected zeros",
                  left_data, right_data, left_valid, right_valid, frame_err);
      end

      // R2 standard I2S on lane 0, R1 lane 1 carries complement
      set_cfg(0, 3'b100, 0);
      send_frame(32, 24'h123456, 24'hABCDEF, 0, 0, "R8 warmup");
      send_frame(32, 24'h800001, 24'h7FFFFE, 1, 0, "R2 I2S 32-slot");
      send_frame(32, 24'hC3A55A, 24'h0F0F0F, 1, 0, "R2 I2S 32-slot b");
      send_frame(32, 24'h000000, 24'hFFFFFF, 0, 0, "tail");

      // R3 right-justified 16 on lane 1
      set_cfg(1, 3'b001, 16);
      send_frame(32, 24'h001111, 24'h002222, 0, 0, "R8 warmup");
      send_frame(32, 24'h00F234, 24'h007ABC, 1, 0, "R3 RJ16 R1 lane1");
      send_frame(32, 24'h008000, 24'h00FFFF, 1, 0, "R3 RJ16 edge");
      send_frame(32, 24'h000000, 24'h000000, 0, 0, "tail");

      // R4 right-justified 18 on lane 0
      set_cfg(0, 3'b010, 18);
      send_frame(24, 24'h011111, 24'h022222, 0, 0, "R8 warmup");
      send_frame(24, 24'h02ABCD, 24'h01ABCD, 1, 0, "R4 RJ18");
      send_frame(24, 24'h020000, 24'h01FFFF, 1, 0, "R4 RJ18 edge");
      send_frame(24, 24'h000000, 24'h000000, 0, 0, "tail");

      // R5 right-justified 20 on lane 1, R7 256-edge frame accepted
      set_cfg(1, 3'b011, 20);
      send_frame(32, 24'h011111, 24'h022222, 0, 0, "R8 warmup");
      send_frame(128, 24'h0ABCDE, 24'h054321, 1, 0, "R5 RJ20 R7 256 edges");
      send_frame(32, 24'h080000, 24'h07FFFF, 1, 0, "R5 RJ20 edge");
      send_frame(32, 24'h000000, 24'h000000, 0, 0, "tail");

      // R9 code 000, short I2S word zero fill (R2)
      set_cfg(0, 3'b000, 0);
      send_frame(32, 24'h111111, 24'h222222, 0, 0, "R8 warmup");
      send_frame(16, 24'hDEADBE, 24'h5A5A5A, 1, 0, "R9 code000 R2 16-bit word");
      send_frame(32, 24'h000000, 24'h000000, 0, 0, "tail");

      // R9 code 110, R7 length limits
      set_cfg(1, 3'b110, 0);
      send_frame(32, 24'h111111, 24'h222222, 0, 0, "R8 warmup");
      send_frame(8, 24'hA50000, 24'h3C0000, 1, 0, "R9 code110 R7 16 edges");
      send_frame(6, 24'hFFFFFF, 24'hFFFFFF, 1, 1, "R7 12 edges error");
      send_frame(129, 24'h123456, 24'h654321, 1, 1, "R7 258 edges error");
      send_frame(32, 24'h13579B, 24'h2468AC, 1, 0, "R7 recovery");
      send_frame(32, 24'h000000, 24'h000000, 0, 0, "tail");

      // R9 code 111 exact 24-bit words
      set_cfg(0, 3'b111, 0);
      send_frame(24, 24'h111111, 24'h222222, 0, 0, "R8 warmup");
      send_frame(24, 24'h876543, 24'h345678, 1, 0, "R9 code111 24-slot");
      send_frame(24, 24'h000000, 24'h000000, 0, 0, "tail");

      // R9 code 101 on lane 1
      set_cfg(1, 3'b101, 0);
      send_frame(32, 24'h111111, 24'h222222, 0, 0, "R8 warmup");
      send_frame(32, 24'hFEDCBA, 24'h010203, 1, 0, "R9 code101 R1 lane1");
      send_frame(32, 24'h000000, 24'h000000, 0, 0, "tail");

      set_cfg(0, 3'b100, 0);
      repeat (40) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R6 missing outputs actual %0d pending expected 0", exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule